// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers up to twenty-nine interrupt event lines into one latched cause word and gates that word with a software-owned enable mask. A rising edge on any source line records a pending event in the cause word. The event stays recorded until software acknowledges it. To acknowledge, software writes the cause register with zeros in the positions it wants cleared and ones everywhere else. It can therefore write back the word it read with only the serviced bit dropped.

Three positions of the cause word that no source owns carry read-only summaries, so a handler can test a whole group of sources at once. Each summary is the OR of a different group of source bits and ignores the mask. The block also raises a single interrupt request when an enabled source is pending. It reports the index of the lowest enabled pending source, which is the one a handler should serve first.

Register access is a single-cycle write strobe plus a combinational read data path. Address 0 selects the cause word and address 1 selects the mask word.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the stored cause bits and all 32 mask bits are 0, `irq_o` is low and `irq_idx_o` is 0.
- R2: A 0-to-1 change on source line n (n in 1..29), seen between two rising clock edges, sets cause bit n at the next rising edge. A line held high sets nothing more after its bit has been cleared.
- R3: A write to address 0 ANDs cause bits 29:1 with the write data. The write data bits at positions 0, 30 and 31 have no effect.
- R4: Cause read bit 0 equals the OR of cause bits 29:1.
- R5: Cause read bit 30 equals the OR of cause bits 29:26 and 20:1.
- R6: Cause read bit 31 equals the OR of cause bits 25:1.
- R7: A write to address 1 replaces all 32 mask bits, and a read of address 1 returns them unchanged. Mask bit n set to 1 enables source n.
- R8: When a source edge and a cause write that clears the same bit act on the same clock edge, the bit ends up set.
- R9: `irq_o` is high exactly when some bit n in 29:1 is set in both the cause word and the mask.
- R10: While `irq_o` is high, `irq_idx_o` is the lowest n in 1..29 that is pending and enabled. While `irq_o` is low, `irq_idx_o` is 0.
- R11: The summary bits at positions 0, 30 and 31 are formed from the stored cause bits whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 29 | Event lines for sources 29 down to 1 |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 1 | Register select: 0 is cause, 1 is mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt request for enabled pending sources |
| irq_idx_o | output | 5 | Lowest enabled pending source index, 0 when idle |

## Verification
A source edge or a register write becomes visible one rising edge later. At that edge the cause and mask registers load. The read word, the summary bits, `irq_o` and `irq_idx_o` are all combinational from those registers, so they follow in the same cycle with no further delay. The bench changes inputs only just after a falling edge and lets exactly one rising edge pass. It then reads both addresses a nanosecond apart before the next rising edge. Source lines stay at their new level across the following steps, so that an edge is never counted twice.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;

    localparam int DATA_W  = 32;
    localparam int SRC_LO  = 1;
    localparam int SRC_HI  = 29;
    localparam int NSRC    = SRC_HI - SRC_LO + 1;
    localparam int IDX_W   = $clog2(SRC_HI + 1);
    localparam int ADDR_W  = 1;
    localparam int NSUM    = 3;

    localparam logic [ADDR_W-1:0] ADDR_CAUSE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(1);

    // Summary bit positions inside the cause word and the source groups they cover.
    localparam int SUM_POS [NSUM] = '{0, 30, 31};
    localparam logic [DATA_W-1:0] SUM_SEL [NSUM] = '{
        32'h3FFF_FFFE,   // every source, 29:1
        32'h3C1F_FFFE,   // 29:26 together with 20:1
        32'h03FF_FFFE    // 25:1
    };

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int N = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = lvl_i & ~st_q.prev;

endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
    import irq_cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [SRC_HI:SRC_LO] set_i,
    output logic [SRC_HI:SRC_LO] cause_o,
    output logic [DATA_W-1:0]    mask_o
);

    typedef struct packed {
        logic [SRC_HI:SRC_LO] cause;
        logic [DATA_W-1:0]    mask;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i && (addr_i == ADDR_CAUSE)) begin
            r_d.cause = r_q.cause & wdata_i[SRC_HI:SRC_LO];
        end
        if (wr_en_i && (addr_i == ADDR_MASK)) begin
            r_d.mask = wdata_i;
        end
        // An arriving event always overrides a clear in the same cycle.
        r_d.cause = r_d.cause | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cause_o = r_q.cause;
    assign mask_o  = r_q.mask;

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_cc_pkg::*;
(
    input  logic [SRC_HI:SRC_LO] cause_i,
    output logic [DATA_W-1:0]    word_o
);

    logic [DATA_W-1:0] full;
    logic [NSUM-1:0]   sum;

    always_comb begin
        full = '0;
        full[SRC_HI:SRC_LO] = cause_i;
    end

    for (genvar g = 0; g < NSUM; g++) begin : g_sum
        assign sum[g] = |(full & SUM_SEL[g]);
    end

    always_comb begin
        word_o = full;
        for (int g = 0; g < NSUM; g++) begin
            word_o[SUM_POS[g]] = sum[g];
        end
    end

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc
    import irq_cc_pkg::*;
(
    input  logic [SRC_HI:SRC_LO] pend_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = SRC_HI; i >= SRC_LO; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_cc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_HI:SRC_LO] src_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o,
    output logic [IDX_W-1:0]     irq_idx_o
);

    logic [SRC_HI:SRC_LO] src_edge;
    logic [SRC_HI:SRC_LO] cause_raw;
    logic [DATA_W-1:0]    mask_q;
    logic [DATA_W-1:0]    cause_word;
    logic [SRC_HI:SRC_LO] pend;
    logic                 any_pend;
    logic [IDX_W-1:0]     low_idx;

    irq_edge_det #(.N(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_i),
        .rise_o (src_edge)
    );

    irq_cause_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .set_i   (src_edge),
        .cause_o (cause_raw),
        .mask_o  (mask_q)
    );

    irq_summary u_sum (
        .cause_i (cause_raw),
        .word_o  (cause_word)
    );

    assign pend = cause_raw & mask_q[SRC_HI:SRC_LO];

    irq_lowest_enc u_enc (
        .pend_i (pend),
        .any_o  (any_pend),
        .idx_o  (low_idx)
    );

    always_comb begin
        case (addr_i)
            ADDR_CAUSE: rdata_o = cause_word;
            ADDR_MASK:  rdata_o = mask_q;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o     = any_pend;
    assign irq_idx_o = any_pend ? low_idx : '0;

endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
    import irq_cc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [DATA_W-1:0]    wdata_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic                 irq_o,
    input logic [IDX_W-1:0]     irq_idx_o,
    input logic [SRC_HI:SRC_LO] src_edge,
    input logic [SRC_HI:SRC_LO] cause_raw,
    input logic [DATA_W-1:0]    mask_q
);

    logic [DATA_W-1:0] pend_ext;
    logic [DATA_W-1:0] below_idx;

    always_comb begin
        pend_ext = '0;
        pend_ext[SRC_HI:SRC_LO] = cause_raw & mask_q[SRC_HI:SRC_LO];
        below_idx = (DATA_W'(1) << irq_idx_o) - DATA_W'(1);
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cause_raw == '0 && mask_q == '0 && !irq_o));

    a_r3_cause_and: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_CAUSE && src_edge == '0)
        |=> cause_raw == ($past(cause_raw) & $past(wdata_i[SRC_HI:SRC_LO])));

    a_r4_sum_all: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_CAUSE) |-> (rdata_o[0] == |rdata_o[29:1]));

    a_r5_sum_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_CAUSE) |-> (rdata_o[30] == (|rdata_o[29:26] || |rdata_o[20:1])));

    a_r6_sum_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_CAUSE) |-> (rdata_o[31] == |rdata_o[25:1]));

    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_MASK) |=> mask_q == $past(wdata_i));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_edge) |=> ((cause_raw & $past(src_edge)) == $past(src_edge)));

    a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_idx_o >= IDX_W'(SRC_LO) && irq_idx_o <= IDX_W'(SRC_HI)
                   && pend_ext[irq_idx_o] && (pend_ext & below_idx) == '0));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_idx_o == '0 && pend_ext == '0));

endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .irq_idx_o (irq_idx_o),
    .src_edge  (src_edge),
    .cause_raw (cause_raw),
    .mask_q    (mask_q)
);

// File: tb/test_irq_cause_ctrl.sv
module test_irq_cause_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:1] src = '0;
    logic        wr_en = 1'b0;
    logic [0:0]  addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [4:0]  irq_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_cause_ctrl i_irq_cause_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .irq_idx_o (irq_idx)
    );

    typedef struct packed {
        logic [31:0] src;
        logic        we;
        logic        adr;
        logic [31:0] wd;
        logic [31:0] exp_cause;
        logic [31:0] exp_mask;
        logic        exp_irq;
        logic [4:0]  exp_idx;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_0000, 1'b1, 1'b1, 32'h0000_0006, 32'h0000_0000, 32'h0000_0006, 1'b0, 5'd0},
        '{32'h0000_0020, 1'b0, 1'b0, 32'h0000_0000, 32'hC000_0021, 32'h0000_0006, 1'b0, 5'd0},
        '{32'h0000_0024, 1'b0, 1'b0, 32'h0000_0000, 32'hC000_0025, 32'h0000_0006, 1'b1, 5'd2},
        '{32'h0000_0024, 1'b1, 1'b0, 32'hFFFF_FFFB, 32'hC000_0021, 32'h0000_0006, 1'b0, 5'd0},
        '{32'h0800_0024, 1'b0, 1'b0, 32'h0000_0000, 32'hC800_0021, 32'h0000_0006, 1'b0, 5'd0},
        '{32'h0800_0024, 1'b1, 1'b0, 32'hFFFF_FFDF, 32'h4800_0001, 32'h0000_0006, 1'b0, 5'd0},
        '{32'h0800_0024, 1'b1, 1'b1, 32'h0800_0002, 32'h4800_0001, 32'h0800_0002, 1'b1, 5'd27},
        '{32'h0040_0000, 1'b0, 1'b0, 32'h0000_0000, 32'hC840_0001, 32'h0800_0002, 1'b1, 5'd27},
        '{32'h0040_0000, 1'b1, 1'b0, 32'hF7FF_FFFF, 32'h8040_0001, 32'h0800_0002, 1'b0, 5'd0},
        '{32'h0040_0002, 1'b1, 1'b0, 32'h0000_0000, 32'hC000_0003, 32'h0800_0002, 1'b1, 5'd1},
        '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hC000_0003, 32'h0800_0002, 1'b1, 5'd1},
        '{32'h2000_0000, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hE000_0003, 32'hFFFF_FFFF, 1'b1, 5'd1},
        '{32'h2000_0000, 1'b1, 1'b0, 32'hFFFF_FFFD, 32'h6000_0001, 32'hFFFF_FFFF, 1'b1, 5'd29},
        '{32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 5'd0}
    };

    task automatic check(input string what, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, act, exp);
        end
    endtask

    // Drive one step just after a falling edge, let one rising edge pass, then sample.
    task automatic step(input logic [29:1] s, input logic we, input logic a,
                        input logic [31:0] wd);
        src   = s;
        wr_en = we;
        addr  = a;
        wdata = wd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_both(output logic [31:0] c, output logic [31:0] m);
        addr = 1'b0;
        #1 c = rdata;
        addr = 1'b1;
        #1 m = rdata;
    endtask

    initial begin
        logic [31:0] c, m;
        repeat (3) @(negedge clk);
        // R1: state while reset is held.
        read_both(c, m);
        check("cause in reset", "R1", c, 32'h0);
        check("mask in reset", "R1", m, 32'h0);
        check("irq in reset", "R1", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_both(c, m);
        check("cause after reset", "R1", c, 32'h0);
        check("idx after reset", "R1", {27'd0, irq_idx}, 32'h0);

        // Vector walk covering R2 R3 R4 R5 R6 R7 R8 R9 R10 R11.
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v].src[29:1], VEC[v].we, VEC[v].adr, VEC[v].wd);
            read_both(c, m);
            check($sformatf("vec %0d cause word", v), "R2/R3/R4/R5/R6/R8/R11", c, VEC[v].exp_cause);
            check($sformatf("vec %0d mask", v), "R7", m, VEC[v].exp_mask);
            check($sformatf("vec %0d irq", v), "R9", {31'd0, irq}, {31'd0, VEC[v].exp_irq});
            check($sformatf("vec %0d idx", v), "R10", {27'd0, irq_idx}, {27'd0, VEC[v].exp_idx});
        end

        // R1: reset in the middle of activity returns everything to zero.
        step(29'h4, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b0;
        #2;
        read_both(c, m);
        check("cause during mid reset", "R1", c, 32'h0);
        check("mask during mid reset", "R1", m, 32'h0);
        src = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_both(c, m);
        check("irq after mid reset", "R1", {31'd0, irq}, 32'h0);

        // R2 and R10: every source line alone, with all sources enabled.
        step('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        for (int n = 1; n <= 29; n++) begin
            step('0, 1'b1, 1'b0, 32'h0);
            step(29'(1) << (n - 1), 1'b0, 1'b0, 32'h0);
            read_both(c, m);
            check($sformatf("source %0d latched", n), "R2", {31'd0, c[n]}, 32'h1);
            check($sformatf("source %0d index", n), "R10", {27'd0, irq_idx}, n);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule